// File: doc/BRIEF.md
# Light-Load Conduction Mode Controller

This block decides, one switching period at a time, whether the low-side switch of a synchronous buck stage runs as a synchronous rectifier on every cycle or imitates a diode under light load. A mode-select input forces continuous conduction when high. When it is low, the block watches a switch-node polarity sample. That sample is captured only on cycles where the low-side switch actually conducted. A high sample means the inductor current has reversed.

A run of `RUN_LEN` reversed samples in a row arms diode emulation. The mode then changes at the next PWM pulse strobe. One forward sample breaks the run, and the mode returns to continuous conduction at the following strobe. While diode emulation is active, the block drops its low-side enable qualifier whenever reverse current is seen. An audio-band watchdog raises a one-cycle extra-pulse request if no PWM strobe arrives for longer than a programmable gap. This keeps the switching rate above the audible range.

Top module: `dem_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dem_active_o` is 0, `ls_enable_o` is 1 and `force_pulse_o` is 0.
- R2: A clock edge with `force_ccm_i` high clears `dem_active_o` and sets `ls_enable_o` to 1. It also empties the reversed-sample run, so that after release `RUN_LEN` fresh reversed samples are needed again.
- R3: `dem_active_o` becomes 1 at the first edge with `pwm_pulse_i` high after `RUN_LEN` (default 8) consecutive valid samples with `sw_pos_i` = 1. `RUN_LEN`-1 such samples are not enough.
- R4: A valid sample with `sw_pos_i` = 0 empties the run. `dem_active_o` then stays unchanged until the next `pwm_pulse_i` edge, where it falls to 0.
- R5: Cycles with `ls_sample_vld_i` low leave the run unchanged, whatever `sw_pos_i` is.
- R6: Apart from R2, `dem_active_o` changes only at edges where `pwm_pulse_i` is high.
- R7: One cycle after an edge where `dem_active_o` is 1, `sw_pos_i` is 1 and `force_ccm_i` is 0, `ls_enable_o` is 0. After any other edge it is 1.
- R8: While `dem_active_o` is 1, if `WD_LIMIT`+1 edges pass with no `pwm_pulse_i` (`WD_LIMIT` = `CLK_MHZ`*`WD_US`), `force_pulse_o` goes high for exactly one cycle, and the gap count restarts. A strobe restarts the count. The request never rises after an edge at which `dem_active_o` was 0.
- R9: The run saturates at `RUN_LEN`. Extra reversed samples keep diode emulation armed, so that later strobes keep `dem_active_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_ccm_i | input | 1 | High forces continuous conduction |
| pwm_pulse_i | input | 1 | One-cycle strobe at each PWM pulse |
| ls_sample_vld_i | input | 1 | Polarity sample valid (low-side switch conducted) |
| sw_pos_i | input | 1 | Switch-node polarity; 1 = reverse inductor current |
| dem_active_o | output | 1 | Diode emulation active |
| ls_enable_o | output | 1 | Low-side gate qualifier; 0 blanks the gate |
| force_pulse_o | output | 1 | One-cycle extra-pulse request from the audio watchdog |

## Verification
The properties assume that `pwm_pulse_i` is a strobe whose meaning does not depend on its width. They also assume that `sw_pos_i` matters only when `ls_sample_vld_i` is high or when it feeds the low-side blanking. The bench keeps strobes sparse, so that runs of reversed samples can build between them. It biases `sw_pos_i` toward reverse current so that diode emulation is actually reached, and it holds `force_ccm_i` high only rarely. Directed phases place the watchdog gap and the entry and exit boundaries on exact cycles, which random stimulus would seldom hit.

// File: rtl/dem_pkg.sv
package dem_pkg;

  typedef enum logic {
    MODE_CCM = 1'b0,
    MODE_DEM = 1'b1
  } cond_mode_e;

  // clock cycles in the audio watchdog window
  function automatic int unsigned gap_cycles(input int unsigned clk_mhz,
                                             input int unsigned gap_us);
    return clk_mhz * gap_us;
  endfunction

endpackage

// File: rtl/dem_run_track.sv
module dem_run_track #(
  parameter int unsigned RUN_LEN = 8,
  parameter int unsigned CW      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic smp_vld_i,
  input  logic smp_pos_i,
  output logic armed_o
);

  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      run_q <= '0;
    end else if (smp_vld_i) begin
      if (!smp_pos_i)        run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
    end
  end

  assign armed_o = (run_q == FULL);

  a_r9_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run_q <= FULL);
  a_r5_no_sample_hold: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld_i && !clr_i) |=> $stable(run_q));
  a_r4_neg_empties: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && !smp_pos_i) |=> (run_q == '0));

endmodule

// File: rtl/dem_mode_reg.sv
module dem_mode_reg
  import dem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       force_ccm_i,
  input  logic       pwm_i,
  input  logic       armed_i,
  input  logic       sw_pos_i,
  output cond_mode_e mode_o,
  output logic       ls_en_o
);

  cond_mode_e mode_q;
  logic       ls_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_CCM;
    end else if (force_ccm_i) begin
      mode_q <= MODE_CCM;
    end else if (pwm_i) begin
      mode_q <= armed_i ? MODE_DEM : MODE_CCM;
    end
  end

  // blank the low side while reverse current is seen in emulation mode
  always_ff @(posedge clk) begin
    if (rst) ls_en_q <= 1'b1;
    else     ls_en_q <= force_ccm_i || !((mode_q == MODE_DEM) && sw_pos_i);
  end

  assign mode_o  = mode_q;
  assign ls_en_o = ls_en_q;

  a_r6_mode_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (!pwm_i && !force_ccm_i) |=> $stable(mode_q));
  a_r2_force_exit: assert property (@(posedge clk) disable iff (rst)
    force_ccm_i |=> (mode_q == MODE_CCM && ls_en_q));
  a_r3_entry_needs_run: assert property (@(posedge clk) disable iff (rst)
    (pwm_i && !armed_i) |=> (mode_q == MODE_CCM));

endmodule

// File: rtl/dem_audio_wdog.sv
module dem_audio_wdog #(
  parameter int unsigned LIMIT = 4000,
  parameter int unsigned GW    = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic dem_i,
  input  logic pwm_i,
  output logic req_o
);

  localparam logic [GW-1:0] GAP_MAX = GW'(LIMIT);

  logic [GW-1:0] gap_q;
  logic          req_q;

  always_ff @(posedge clk) begin
    if (rst || !dem_i || pwm_i) begin
      gap_q <= '0;
      req_q <= 1'b0;
    end else if (gap_q == GAP_MAX) begin
      gap_q <= '0;
      req_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
  a_r8_quiet_outside_dem: assert property (@(posedge clk) disable iff (rst)
    !dem_i |=> !req_q);
  a_r8_gap_bounded: assert property (@(posedge clk) disable iff (rst)
    gap_q <= GAP_MAX);

endmodule

// File: rtl/dem_mode_ctrl.sv
module dem_mode_ctrl
  import dem_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned WD_US   = 40,
  parameter bit          WDOG_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic force_ccm_i,
  input  logic pwm_pulse_i,
  input  logic ls_sample_vld_i,
  input  logic sw_pos_i,
  output logic dem_active_o,
  output logic ls_enable_o,
  output logic force_pulse_o
);

  localparam int unsigned RUN_W    = $clog2(RUN_LEN + 1);
  localparam int unsigned WD_LIMIT = gap_cycles(CLK_MHZ, WD_US);
  localparam int unsigned GAP_W    = $clog2(WD_LIMIT + 1);

  logic       armed;
  cond_mode_e mode;

  dem_run_track #(.RUN_LEN(RUN_LEN), .CW(RUN_W)) u_run (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (force_ccm_i),
    .smp_vld_i (ls_sample_vld_i),
    .smp_pos_i (sw_pos_i),
    .armed_o   (armed)
  );

  dem_mode_reg u_mode (
    .clk         (clk),
    .rst         (rst),
    .force_ccm_i (force_ccm_i),
    .pwm_i       (pwm_pulse_i),
    .armed_i     (armed),
    .sw_pos_i    (sw_pos_i),
    .mode_o      (mode),
    .ls_en_o     (ls_enable_o)
  );

  assign dem_active_o = (mode == MODE_DEM);

  generate
    if (WDOG_EN) begin : g_wdog
      dem_audio_wdog #(.LIMIT(WD_LIMIT), .GW(GAP_W)) u_wdog (
        .clk   (clk),
        .rst   (rst),
        .dem_i (dem_active_o),
        .pwm_i (pwm_pulse_i),
        .req_o (force_pulse_o)
      );
    end else begin : g_no_wdog
      assign force_pulse_o = 1'b0;
    end
  endgenerate

  a_r7_reverse_blank: assert property (@(posedge clk) disable iff (rst)
    (dem_active_o && sw_pos_i && !force_ccm_i) |=> !ls_enable_o);
  a_r7_ccm_drives: assert property (@(posedge clk) disable iff (rst)
    !dem_active_o |=> ls_enable_o);

endmodule

// File: tb/dem_mode_ctrl_bench.sv
module dem_mode_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RUN        = 8;
  localparam int MHZ        = 2;
  localparam int US         = 10;
  localparam int LIM        = MHZ * US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fccm = 1'b0, pwm = 1'b0, vld = 1'b0, pos = 1'b0;
  logic dem_o, lsen_o, req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  int   m_run, m_gap;
  logic m_dem, m_lsen, m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  dem_mode_ctrl #(.RUN_LEN(RUN), .CLK_MHZ(MHZ), .WD_US(US), .WDOG_EN(1'b1))
  u_dem_mode_ctrl (
    .clk             (clk),
    .rst             (rst),
    .force_ccm_i     (fccm),
    .pwm_pulse_i     (pwm),
    .ls_sample_vld_i (vld),
    .sw_pos_i        (pos),
    .dem_active_o    (dem_o),
    .ls_enable_o     (lsen_o),
    .force_pulse_o   (req_o)
  );

  function automatic int f_run(int r, logic f, logic v, logic s);
    if (f)  return 0;
    if (!v) return r;
    if (!s) return 0;
    return (r >= RUN) ? RUN : r + 1;
  endfunction

  function automatic logic f_dem(logic d, int r, logic f, logic p);
    if (f) return 1'b0;
    if (p) return (r == RUN);
    return d;
  endfunction

  function automatic logic f_lsen(logic d, logic f, logic s);
    return f | !(d & s);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic p, input logic v, input logic s,
                     input string tag);
    int   nr;
    logic nd;
    @(negedge clk);
    fccm = f; pwm = p; vld = v; pos = s;
    @(posedge clk);
    nr = f_run(m_run, f, v, s);
    nd = f_dem(m_dem, m_run, f, p);
    m_lsen = f_lsen(m_dem, f, s);
    if (!m_dem || p) begin
      m_gap = 0; m_req = 1'b0;
    end else if (m_gap == LIM) begin
      m_gap = 0; m_req = 1'b1;
    end else begin
      m_gap++; m_req = 1'b0;
    end
    m_run = nr;
    m_dem = nd;
    #1;
    chk({tag, " mode"}, dem_o, m_dem);
    chk({tag, " lsen"}, lsen_o, m_lsen);
    chk({tag, " req"}, req_o, m_req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_d00d));
    m_run = 0; m_gap = 0; m_dem = 1'b0; m_lsen = 1'b1; m_req = 1'b0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mode", dem_o, 1'b0);
    chk("R1 lsen", lsen_o, 1'b1);
    chk("R1 req", req_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    cyc(0, 0, 0, 0, "R1");

    // R3: one short of the run does not arm
    for (int i = 0; i < RUN - 1; i++) cyc(0, 0, 1, 1, "R3");
    cyc(0, 1, 0, 0, "R3");
    chk("R3 short run", dem_o, 1'b0);
    cyc(0, 0, 1, 1, "R3");
    // R6: armed but no strobe yet
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R6");
    chk("R6 wait strobe", dem_o, 1'b0);
    cyc(0, 1, 0, 0, "R3");
    chk("R3 entry", dem_o, 1'b1);

    // R7: blanking follows polarity
    cyc(0, 0, 0, 1, "R7");
    chk("R7 blank", lsen_o, 1'b0);
    cyc(0, 0, 0, 0, "R7");
    chk("R7 drive", lsen_o, 1'b1);

    // R5: unsampled cycles keep the run
    cyc(0, 0, 0, 0, "R5");
    cyc(0, 1, 0, 1, "R5");
    chk("R5 hold", dem_o, 1'b1);

    // R9: saturation keeps it armed
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, "R9");
    cyc(0, 1, 0, 0, "R9");
    chk("R9 sat", dem_o, 1'b1);

    // R8: watchdog fires on the exact cycle
    for (int k = 1; k <= LIM + 1; k++) begin
      cyc(0, 0, 0, 0, "R8");
      chk("R8 gap", req_o, (k == LIM + 1));
    end
    cyc(0, 0, 0, 0, "R8");
    chk("R8 one cycle", req_o, 1'b0);

    // R4: forward sample exits only at next strobe
    cyc(0, 0, 1, 0, "R4");
    cyc(0, 0, 0, 0, "R4");
    chk("R4 before strobe", dem_o, 1'b1);
    cyc(0, 1, 0, 0, "R4");
    chk("R4 exit", dem_o, 1'b0);

    // R8: silent outside emulation
    for (int k = 0; k < LIM + 5; k++) begin
      cyc(0, 0, 0, 0, "R8");
      chk("R8 ccm quiet", req_o, 1'b0);
    end

    // R2: forced continuous mode
    for (int i = 0; i < RUN; i++) cyc(0, 0, 1, 1, "R2");
    cyc(0, 1, 0, 0, "R2");
    cyc(1, 0, 0, 1, "R2");
    chk("R2 exit", dem_o, 1'b0);
    chk("R2 lsen", lsen_o, 1'b1);
    for (int i = 0; i < RUN - 1; i++) cyc(0, 0, 1, 1, "R2");
    cyc(0, 1, 0, 0, "R2");
    chk("R2 run cleared", dem_o, 1'b0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic f, p, v, s;
      f = ($urandom_range(0, 99) < 2);
      p = ($urandom_range(0, 5) == 0);
      v = ($urandom_range(0, 1) == 1);
      s = ($urandom_range(0, 99) < 88);
      cyc(f, p, v, s, "R6 random");
    end
    // long gaps in random emulation
    for (int i = 0; i < RUN; i++) cyc(0, 0, 1, 1, "R8 random");
    cyc(0, 1, 0, 0, "R8 random");
    for (int i = 0; i < 3 * (LIM + 1); i++)
      cyc(0, 0, 0, $urandom_range(0, 1), "R8 random");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule